// File: doc/BRIEF.md
# Packet Device Register Controller

This block is the register front end of a simple packet network device. Software reaches it over a 32-bit word-addressed register bus that has an address, a write enable, write data and a combinational read-data return. The block holds the device's configuration registers. It runs three small state machines: device power, transmit and receive. It drives a start request toward an external transmit engine and takes that engine's completion pulse. It takes receive-complete events, each carrying a length, from an external receive engine. The engines themselves, data movement, DMA and framing all sit outside this block. A one-cycle interrupt pulse marks each finished transfer.

Word index = `bus_addr[ADDR_W-1:2]`, and bits 1:0 are ignored. The map is: 0x00 control, 0x04 status (read-only), 0x08 transmit length, 0x0C transmit pointer, 0x10 receive length, 0x14 receive pointer, 0x18 interrupt configuration. Index 7 (0x1C) is unmapped and reads zero. Control bits: 0 start-up strobe, 1 interrupt enable, 2 shutdown strobe, 3 send strobe, 4 receive-acknowledge strobe, 5 receive enable. Status bits: 0 device up, 1 transmit available, 2 packet held.

The device machine has the states DEV_DOWN and DEV_UP. A start-up strobe moves it from DEV_DOWN to DEV_UP, and a shutdown strobe moves it from DEV_UP to DEV_DOWN. The transmit machine has the states TX_OFF, TX_AVAIL and TX_BUSY. A start-up strobe takes it from TX_OFF to TX_AVAIL. A send strobe takes it from TX_AVAIL to TX_BUSY. An engine done pulse takes it from TX_BUSY back to TX_AVAIL. A shutdown strobe takes it from TX_AVAIL or TX_BUSY to TX_OFF. The receive machine has the states RX_EMPTY and RX_FULL. An accepted packet takes it from RX_EMPTY to RX_FULL, and it stays in RX_FULL on further packets. An acknowledge strobe or a shutdown strobe takes it from RX_FULL to RX_EMPTY.

Top module: `pktdev_csr`

## Requirements
- R1: After reset, control, status, both lengths and both pointers read 0, the interrupt configuration reads 0x0002_0006, and `irq` and `tx_go` are low.
- R2: The transmit length, transmit pointer, receive length, receive pointer and interrupt configuration words read back what was last written. Address bits 1:0 are ignored, and index 7 reads 0. `tx_addr`/`tx_len` show the stored transmit pointer and length, and `rx_addr` shows the stored receive pointer.
- R3: Control reads return only bit 1 (interrupt enable) and bit 5 (receive enable). The strobe bits 0, 2, 3 and 4 and reserved bits 31:6 read 0. Status bits 31:3 read 0.
- R4: A write with bit 0 set and bit 2 clear makes status bits 0 and 1 read 1 from the next cycle on. A write with bit 2 set clears status bits 0, 1 and 2 and drops any transfer in flight, and it wins over bit 0 in the same write.
- R5: A write with bit 3 set while status bit 1 is 1 raises `tx_go` from the next cycle. `tx_go` stays high and status bit 1 stays 0 until `tx_done` is sampled. One cycle after that, `tx_go` is 0 and status bit 1 is 1.
- R6: A send write while status bit 1 is 0 does not start a transfer. A `tx_done` pulse outside TX_BUSY changes nothing and raises no interrupt.
- R7: A sampled `rx_done` is accepted when the device is up, receive enable is 1 and the receive pointer is nonzero. On acceptance the receive length register takes `rx_len` zero-extended, and status bit 2 becomes 1.
- R8: An `rx_done` that fails any condition of R7 (zero pointer, receive disabled, device down) leaves every register and flag unchanged and raises no interrupt.
- R9: A control write with bit 4 set clears status bit 2. A packet accepted in the same cycle wins, and the bit stays 1.
- R10: `irq` is high for exactly one cycle, the cycle after a transmit completion or a receive acceptance, provided interrupt enable was 1. Simultaneous events give a single pulse, and with interrupt enable at 0 there is no pulse.
- R11: The interrupt configuration holds the vector in bits 15:0 and the level in bits 31:16, and both fields are fully writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tx_go | output | 1 | Transmit request, held high while a transfer runs |
| tx_addr | output | 32 | Stored transmit pointer |
| tx_len | output | 32 | Stored transmit length |
| tx_done | input | 1 | One-cycle completion from the transmit engine |
| rx_done | input | 1 | One-cycle packet-complete event from the receive engine |
| rx_len | input | LEN_W | Length of the completed packet |
| rx_addr | output | 32 | Stored receive pointer |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that the engines pulse `tx_done` and `rx_done` for single cycles and that `rx_len` is valid whenever `rx_done` is high. They also assume that the bus holds address and data steady across the sampling edge of each write. The bench drives every input on the falling edge and holds each pulse for exactly one cycle. It reads back through the combinational read port between edges. It also produces the collisions the properties single out: a shutdown together with a start-up, an acknowledge together with an acceptance, and transmit completion together with receive acceptance.

// File: rtl/pktdev_pkg.sv
package pktdev_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned REG_CNT = 7;

    // word indices; software-visible positions
    localparam int unsigned IDX_CTRL  = 0;
    localparam int unsigned IDX_STAT  = 1;
    localparam int unsigned IDX_TXLEN = 2;
    localparam int unsigned IDX_TXPTR = 3;
    localparam int unsigned IDX_RXLEN = 4;
    localparam int unsigned IDX_RXPTR = 5;
    localparam int unsigned IDX_ICFG  = 6;

    // control bit positions
    localparam int unsigned CB_INIT = 0;
    localparam int unsigned CB_IEN  = 1;
    localparam int unsigned CB_STOP = 2;
    localparam int unsigned CB_SEND = 3;
    localparam int unsigned CB_ACK  = 4;
    localparam int unsigned CB_RXEN = 5;

    // status bit positions
    localparam int unsigned SB_UP   = 0;
    localparam int unsigned SB_TXAV = 1;
    localparam int unsigned SB_RXF  = 2;

    localparam logic [WORD_W-1:0] ICFG_RESET = 32'h0002_0006;

    typedef enum logic {
        DEV_DOWN,
        DEV_UP
    } dev_state_t;

    typedef enum logic [1:0] {
        TX_OFF,
        TX_AVAIL,
        TX_BUSY
    } tx_state_t;

    typedef enum logic {
        RX_EMPTY,
        RX_FULL
    } rx_state_t;

    typedef struct packed {
        logic init;
        logic stop;
        logic send;
        logic ack;
    } strobe_t;

endpackage

// File: rtl/pktdev_decode.sv
module pktdev_decode
    import pktdev_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned REG_N  = REG_CNT,
    localparam int unsigned IDX_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [REG_N-1:0]  reg_we,
    output strobe_t           stb
);

    assign reg_idx = bus_addr[ADDR_W-1:2];

    for (genvar gi = 0; gi < REG_N; gi++) begin : g_we
        assign reg_we[gi] = bus_wr && (reg_idx == IDX_W'(gi));
    end

    always_comb begin
        stb.init = reg_we[IDX_CTRL] & bus_wdata[CB_INIT];
        stb.stop = reg_we[IDX_CTRL] & bus_wdata[CB_STOP];
        stb.send = reg_we[IDX_CTRL] & bus_wdata[CB_SEND];
        stb.ack  = reg_we[IDX_CTRL] & bus_wdata[CB_ACK];
    end

endmodule

// File: rtl/pktdev_dev_fsm.sv
module pktdev_dev_fsm
    import pktdev_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t stb,
    output logic    dev_up
);

    dev_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DEV_DOWN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DEV_DOWN: if (stb.init && !stb.stop) st_d = DEV_UP;
            DEV_UP:   if (stb.stop)              st_d = DEV_DOWN;
            default:  st_d = DEV_DOWN;
        endcase
    end

    always_comb begin
        dev_up = (st_q == DEV_UP);
    end

    assert_stop_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb.stop |=> !dev_up);
    assert_init_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.init && !stb.stop) |=> dev_up);

endmodule

// File: rtl/pktdev_tx_fsm.sv
module pktdev_tx_fsm
    import pktdev_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t stb,
    input  logic    tx_done,
    output logic    tx_go,
    output logic    tx_avail,
    output logic    tx_complete
);

    tx_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_OFF: begin
                if (stb.init && !stb.stop) st_d = TX_AVAIL;
            end
            TX_AVAIL: begin
                if (stb.stop)      st_d = TX_OFF;
                else if (stb.send) st_d = TX_BUSY;
            end
            TX_BUSY: begin
                if (stb.stop)      st_d = TX_OFF;
                else if (tx_done)  st_d = TX_AVAIL;
            end
            default: st_d = TX_OFF;
        endcase
    end

    always_comb begin
        tx_go       = (st_q == TX_BUSY);
        tx_avail    = (st_q == TX_AVAIL);
        tx_complete = (st_q == TX_BUSY) && tx_done && !stb.stop;
    end

    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && !tx_done && !stb.stop) |=> tx_go);
    assert_done_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && tx_done && !stb.stop) |=> (!tx_go && tx_avail));
    assert_send_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_avail && !tx_go && stb.send) |=> !tx_go);

endmodule

// File: rtl/pktdev_rx_fsm.sv
module pktdev_rx_fsm
    import pktdev_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           stb,
    input  logic              dev_up,
    input  logic              rx_en,
    input  logic              ptr_valid,
    input  logic              rx_done,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              size_we,
    input  logic [WORD_W-1:0] size_wdata,
    output logic [WORD_W-1:0] rx_size,
    output logic              rx_full,
    output logic              rx_accept
);

    rx_state_t st_q, st_d;
    logic [WORD_W-1:0] len_ext;

    assign len_ext = WORD_W'(rx_len);

    always_comb begin
        rx_accept = rx_done && dev_up && rx_en && ptr_valid && !stb.stop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_EMPTY: if (rx_accept) st_d = RX_FULL;
            RX_FULL:  if (stb.stop || (stb.ack && !rx_accept)) st_d = RX_EMPTY;
            default:  st_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rx_size <= '0;
        else if (rx_accept) rx_size <= len_ext;
        else if (size_we)   rx_size <= size_wdata;
    end

    always_comb begin
        rx_full = (st_q == RX_FULL);
    end

    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept |=> (rx_full && rx_size == $past(len_ext)));
    assert_drop_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !ptr_valid && !size_we) |=> $stable(rx_size));
    assert_drop_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !ptr_valid && !stb.ack && !stb.stop) |=> $stable(rx_full));
    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.ack && !rx_accept) |=> !rx_full);

endmodule

// File: rtl/pktdev_csr.sv
module pktdev_csr
    import pktdev_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_go,
    output logic [31:0]       tx_addr,
    output logic [31:0]       tx_len,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic [LEN_W-1:0]  rx_len,
    output logic [31:0]       rx_addr,
    output logic              irq
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]   reg_idx;
    logic [REG_CNT-1:0] reg_we;
    strobe_t            stb;

    logic dev_up, tx_avail, tx_complete;
    logic rx_full, rx_accept;
    logic ien_q, rxen_q;
    logic [WORD_W-1:0] txlen_q, txptr_q, rxptr_q, icfg_q, rxsize;

    pktdev_decode #(.ADDR_W(ADDR_W), .REG_N(REG_CNT)) u_dec (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .reg_idx   (reg_idx),
        .reg_we    (reg_we),
        .stb       (stb)
    );

    pktdev_dev_fsm u_dev (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (stb),
        .dev_up (dev_up)
    );

    pktdev_tx_fsm u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb         (stb),
        .tx_done     (tx_done),
        .tx_go       (tx_go),
        .tx_avail    (tx_avail),
        .tx_complete (tx_complete)
    );

    pktdev_rx_fsm #(.LEN_W(LEN_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (stb),
        .dev_up     (dev_up),
        .rx_en      (rxen_q),
        .ptr_valid  (|rxptr_q),
        .rx_done    (rx_done),
        .rx_len     (rx_len),
        .size_we    (reg_we[IDX_RXLEN]),
        .size_wdata (bus_wdata),
        .rx_size    (rxsize),
        .rx_full    (rx_full),
        .rx_accept  (rx_accept)
    );

    // persistent control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            rxen_q <= 1'b0;
        end else if (reg_we[IDX_CTRL]) begin
            ien_q  <= bus_wdata[CB_IEN];
            rxen_q <= bus_wdata[CB_RXEN];
        end
    end

    // plain data words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txlen_q <= '0;
            txptr_q <= '0;
            rxptr_q <= '0;
            icfg_q  <= ICFG_RESET;
        end else begin
            if (reg_we[IDX_TXLEN]) txlen_q <= bus_wdata;
            if (reg_we[IDX_TXPTR]) txptr_q <= bus_wdata;
            if (reg_we[IDX_RXPTR]) rxptr_q <= bus_wdata;
            if (reg_we[IDX_ICFG])  icfg_q  <= bus_wdata;
        end
    end

    // interrupt pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= ien_q && (tx_complete || rx_accept);
    end

    always_comb begin
        tx_addr = txptr_q;
        tx_len  = txlen_q;
        rx_addr = rxptr_q;
    end

    // read return
    always_comb begin
        bus_rdata = '0;
        case (reg_idx)
            IDX_W'(IDX_CTRL): begin
                bus_rdata[CB_IEN]  = ien_q;
                bus_rdata[CB_RXEN] = rxen_q;
            end
            IDX_W'(IDX_STAT): begin
                bus_rdata[SB_UP]   = dev_up;
                bus_rdata[SB_TXAV] = tx_avail;
                bus_rdata[SB_RXF]  = rx_full;
            end
            IDX_W'(IDX_TXLEN): bus_rdata = txlen_q;
            IDX_W'(IDX_TXPTR): bus_rdata = txptr_q;
            IDX_W'(IDX_RXLEN): bus_rdata = rxsize;
            IDX_W'(IDX_RXPTR): bus_rdata = rxptr_q;
            IDX_W'(IDX_ICFG):  bus_rdata = icfg_q;
            default:           bus_rdata = '0;
        endcase
    end

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ien_q && (tx_done || rx_done)));
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |=> !irq);
    assert_status_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_W'(IDX_STAT)) |-> (bus_rdata[31:3] == '0));
    assert_go_not_avail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> !bus_rdata[SB_TXAV] || (reg_idx != IDX_W'(IDX_STAT)));

endmodule

// File: tb/pktdev_csr_tb_top.sv
`timescale 1ns/1ps
module pktdev_csr_tb_top;

    localparam int unsigned AW = 5;
    localparam int unsigned LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          tx_go;
    logic [31:0]   tx_addr, tx_len, rx_addr;
    logic          tx_done = 1'b0;
    logic          rx_done = 1'b0;
    logic [LW-1:0] rx_len = '0;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pktdev_csr #(.ADDR_W(AW), .LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_go(tx_go), .tx_addr(tx_addr), .tx_len(tx_len), .tx_done(tx_done),
        .rx_done(rx_done), .rx_len(rx_len), .rx_addr(rx_addr), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(idx * 4); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int idx, input int off, output logic [31:0] d);
        bus_wr = 1'b0;
        bus_addr = AW'(idx * 4 + off);
        #1;
        d = bus_rdata;
    endtask

    task automatic txdone_pulse();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic rx_pulse(input logic [LW-1:0] len);
        @(negedge clk); rx_done = 1'b1; rx_len = len;
        @(negedge clk); rx_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_ctrl, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R2 unmapped slot
        for (int i = 0; i < 8; i++) begin
            rd(i, 0, d);
            chk((i == 6) ? "R1 icfg reset" : "R1 reset/R2 unmapped", d,
                (i == 6) ? 32'h0002_0006 : 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 tx_go", {31'b0, tx_go}, 0);

        // R2 data words with byte offsets ignored
        for (int r = 2; r <= 6; r++) begin
            if (r == 1) continue;
            for (int k = 0; k < 4; k++) begin
                v = 32'hA5C3_0000 ^ (r << 8) ^ (k * 32'h0101_0F0F);
                wr(r, v);
                rd(r, k, d);
                chk("R2 readback", d, v);
                if (r == 2) chk("R2 tx_len out", tx_len, v);
                if (r == 3) chk("R2 tx_addr out", tx_addr, v);
                if (r == 5) chk("R2 rx_addr out", rx_addr, v);
            end
        end
        wr(6, 32'h0001_0033);
        rd(6, 0, d);
        chk("R11 vector", {16'b0, d[15:0]}, 32'h33);
        chk("R11 level", {16'b0, d[31:16]}, 32'h1);

        // R3/R4/R6 sweep of control values starting from the down state
        for (int c = 0; c < 64; c++) begin
            logic up;
            wr(0, 32'h4);
            wr(0, 32'hFFFF_FFC0 | c);
            up = c[0] && !c[2];
            exp_ctrl = (c & 32'h22);
            rd(0, 0, d);
            chk("R3 control readback", d, exp_ctrl);
            rd(1, 0, d);
            chk("R4 status after control write", d, up ? 32'h3 : 32'h0);
            chk("R6 send from down ignored", {31'b0, tx_go}, 0);
        end

        // R5/R10 transmit runs of varying length, alternating interrupt enable
        wr(0, 32'h4);
        wr(0, 32'h1);
        for (int dly = 0; dly < 6; dly++) begin
            logic ien;
            ien = dly[0];
            wr(0, 32'h1 | (ien << 1));
            wr(0, 32'h8 | (ien << 1));
            chk("R5 tx_go raised", {31'b0, tx_go}, 1);
            if (dly == 2) wr(0, 32'h8 | (ien << 1));
            repeat (dly) @(negedge clk);
            chk("R5 tx_go held", {31'b0, tx_go}, 1);
            rd(1, 0, d);
            chk("R5 avail low while busy", d, 32'h1);
            txdone_pulse();
            chk("R10 irq after tx completion", {31'b0, irq}, {31'b0, ien});
            chk("R5 tx_go released", {31'b0, tx_go}, 0);
            rd(1, 0, d);
            chk("R5 avail restored", d, 32'h3);
            @(negedge clk);
            chk("R10 irq single cycle", {31'b0, irq}, 0);
        end

        // R6 done outside a transfer
        wr(0, 32'h2);
        txdone_pulse();
        chk("R6 stray done no irq", {31'b0, irq}, 0);
        rd(1, 0, d);
        chk("R6 stray done status", d, 32'h3);

        // R4 shutdown mid-transfer, shutdown beats start-up
        wr(0, 32'hA);
        wr(0, 32'h4);
        chk("R4 shutdown drops transfer", {31'b0, tx_go}, 0);
        rd(1, 0, d);
        chk("R4 shutdown status", d, 32'h0);
        txdone_pulse();
        chk("R6 done after shutdown no irq", {31'b0, irq}, 0);
        wr(0, 32'h5);
        rd(1, 0, d);
        chk("R4 stop wins over init", d, 32'h0);

        // R7/R8/R9/R10 receive acceptance sweep
        for (int c = 0; c < 16; c++) begin
            logic up, rxen, pnz, ien, acc;
            logic [LW-1:0] len;
            up = c[0]; rxen = c[1]; pnz = c[2]; ien = c[3];
            acc = up && rxen && pnz;
            len = LW'(40 + c * 3);
            wr(0, 32'h4);
            wr(5, pnz ? 32'h1000 + c : 32'h0);
            wr(4, 32'h600);
            wr(0, {26'b0, rxen, 3'b0, ien, up});
            rx_pulse(len);
            chk(acc ? "R10 irq on accept" : "R8 no irq on drop", {31'b0, irq},
                {31'b0, acc && ien});
            rd(4, 0, d);
            chk(acc ? "R7 length stored" : "R8 length kept", d,
                acc ? {16'b0, len} : 32'h600);
            rd(1, 0, d);
            chk(acc ? "R7 flag set" : "R8 flag kept", d,
                (up ? 32'h3 : 32'h0) | (acc ? 32'h4 : 32'h0));
            wr(0, {26'b0, rxen, 1'b1, 2'b0, ien, 1'b0});
            rd(1, 0, d);
            chk("R9 ack clears flag", d, up ? 32'h3 : 32'h0);
        end

        // R10 simultaneous completion and acceptance: single pulse
        wr(0, 32'h4);
        wr(5, 32'h2000);
        wr(0, 32'h23);
        wr(0, 32'h2A);
        @(negedge clk); tx_done = 1'b1; rx_done = 1'b1; rx_len = 16'd77;
        @(negedge clk); tx_done = 1'b0; rx_done = 1'b0;
        chk("R10 irq on joint events", {31'b0, irq}, 1);
        @(negedge clk);
        chk("R10 joint events single pulse", {31'b0, irq}, 0);
        rd(1, 0, d);
        chk("R7 status after joint events", d, 32'h7);

        // R9 acknowledge colliding with a new packet
        @(negedge clk);
        bus_addr = AW'(0); bus_wdata = 32'h32; bus_wr = 1'b1;
        rx_done = 1'b1; rx_len = 16'd88;
        @(negedge clk);
        bus_wr = 1'b0; rx_done = 1'b0;
        rd(1, 0, d);
        chk("R9 accept wins over ack", d, 32'h7);
        rd(4, 0, d);
        chk("R9 new length on collision", d, 32'd88);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule